// File: doc/BRIEF.md
# Word-Parallel CRC-16 With Ragged Final Word

This block computes a 16-bit cyclic redundancy check over a byte-oriented frame. The frame arrives as 32-bit words, one word per clock. Each accepted full word is folded into the running check value in a single cycle.

Frames need not be a multiple of four bytes long. On the closing word, a 2-bit byte count selects how many of the word's upper bytes take part. The tail is absorbed in the same single cycle as any other word, with no serial finishing pass and no extra clock.

The generator is x^16 + x^15 + x^2 + 1, the polynomial of the USB data-packet check. The register starts at all ones at every frame start. The result is presented as computed: it is neither inverted nor bit-reversed. A one-cycle completion pulse marks the cycle in which the final value first appears on the output. That value then stays put until the next frame begins.

Top module: `crc16_tail32`

## Requirements
- R1: While reset is held, and in the cycle after it, the check output reads 16'hFFFF and the completion pulse is low.
- R2: The final check value equals a bit-serial reference over the same bytes. The reference uses polynomial 16'h8005, start value 16'hFFFF, no output inversion and no reflection. Bytes are taken most significant byte of each word first (bits 31:24 first), and bits within a byte most significant bit first.
- R3: A word presented with frame start and data valid both high restarts the computation from 16'hFFFF and absorbs that word in the same cycle. This holds even while a frame is already open.
- R4: On the closing word, a byte count of 1, 2 or 3 absorbs only bits 31:24, 31:16 or 31:8 respectively. The unused lower bytes have no effect on the result.
- R5: A byte count of 0 on the closing word absorbs all four bytes.
- R6: The completion pulse is high for exactly the one cycle after the closing word is accepted. In that same cycle the output already shows the final check value.
- R7: After the closing word, valid data presented without frame start is ignored. The output keeps the final value and no pulse occurs.
- R8: A cycle with data valid low inside an open frame leaves the running value unchanged.
- R9: Frame start with data valid low loads 16'hFFFF and opens a frame. The words that follow are then accepted without frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Frame start; reinitializes the check register |
| din | input | 32 | Data word, first byte in bits 31:24 |
| din_vld | input | 1 | Data word valid this cycle |
| eof | input | 1 | This valid word closes the frame |
| nbytes | input | 2 | Valid bytes in the closing word (0 means 4) |
| crc | output | 16 | Running, then final, check value |
| done | output | 1 | One-cycle pulse after the closing word |

## Verification
The assertions take for granted that the byte count is only meaningful alongside the end flag. They also assume a frame is closed by exactly one word that carries the end flag. The stimulus holds to this: the count is driven only on closing words, and every frame ends with a single flagged word.

Frame lengths from 1 to 48 bytes are swept, which covers every tail count. Each length is run three ways: words back to back, idle gaps between words, and a frame opened by a start-only cycle. The unused tail bytes always carry random filler, so any leak of those bytes into the result is caught.

// File: rtl/crc16_tail32.sv
module crc16_tail32 #(
  parameter logic [15:0] POLY = 16'h8005,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sof,
  input  logic [31:0] din,
  input  logic        din_vld,
  input  logic        eof,
  input  logic [1:0]  nbytes,
  output logic [15:0] crc,
  output logic        done
);

  logic [15:0] crc_q, seed, t1, t2, t3, t4, nxt;
  logic        active, done_q, take;

  function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ b[i]) ? POLY : 16'h0000);
    return r;
  endfunction

  assign take = din_vld & (sof | active);
  assign seed = sof ? INIT : crc_q;

  assign t1 = fold_byte(seed, din[31:24]);
  assign t2 = fold_byte(t1,   din[23:16]);
  assign t3 = fold_byte(t2,   din[15:8]);
  assign t4 = fold_byte(t3,   din[7:0]);

  always_comb begin
    nxt = t4;
    if (eof) begin
      case (nbytes)
        2'd1:    nxt = t1;
        2'd2:    nxt = t2;
        2'd3:    nxt = t3;
        default: nxt = t4;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q  <= INIT;
      active <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= take & eof;
      if (take) begin
        crc_q  <= nxt;
        active <= ~eof;
      end else if (sof) begin
        crc_q  <= INIT;
        active <= 1'b1;
      end
    end
  end

  assign crc  = crc_q;
  assign done = done_q;

endmodule

// File: rtl/crc16_tail32_chk.sv
module crc16_tail32_chk (
  input logic        clk,
  input logic        rst,
  input logic        sof,
  input logic        din_vld,
  input logic        eof,
  input logic        active,
  input logic        done,
  input logic [15:0] crc
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (crc == 16'hFFFF && !done));

  p_done_follows_close_r6: assert property (@(posedge clk) disable iff (rst)
    (din_vld && eof && (sof || active)) |=> done);

  p_done_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(din_vld && eof));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!din_vld && !sof) |=> $stable(crc));

  p_closed_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (!active && !sof) |=> ($stable(crc) && !done));

  p_start_only_init_r9: assert property (@(posedge clk) disable iff (rst)
    (sof && !din_vld) |=> (crc == 16'hFFFF));

endmodule

bind crc16_tail32 crc16_tail32_chk u_chk (
  .clk(clk), .rst(rst), .sof(sof), .din_vld(din_vld), .eof(eof),
  .active(active), .done(done), .crc(crc)
);

// File: tb/crc16_tail32_test.sv
module crc16_tail32_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1, sof = 1'b0, din_vld = 1'b0, eof = 1'b0;
  logic [31:0] din = '0;
  logic [1:0]  nbytes = '0;
  logic [15:0] crc;
  logic        done;

  int checks = 0, fails = 0;
  logic [7:0]  fb [0:63];
  logic [31:0] lcg = 32'h1234_5678;

  crc16_tail32 uut (.clk(clk), .rst(rst), .sof(sof), .din(din), .din_vld(din_vld),
                    .eof(eof), .nbytes(nbytes), .crc(crc), .done(done));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < len; k++)
      for (int i = 7; i >= 0; i--) begin
        logic f;
        f = c[15] ^ fb[k][i];
        c = c << 1;
        if (f) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic e,
                       input logic [1:0] nb, input logic [31:0] d);
    @(negedge clk);
    sof = s; din_vld = v; eof = e; nbytes = nb; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic fill_random();
    for (int k = 0; k < 64; k++) fb[k] = rnd8();
  endtask

  task automatic run_frame(input int len, input bit gap, input bit lead_sof);
    int nw;
    logic [15:0] exp;
    string tag;
    nw  = (len + 3) / 4;
    exp = ref_crc(len);
    tag = (len % 4 == 0) ? "R2/R5 full tail" : "R2/R4 partial tail";
    if (lead_sof) begin
      drive(1'b1, 1'b0, 1'b0, 2'd0, {rnd8(), rnd8(), rnd8(), rnd8()});
      chk("R9 start-only init", crc, 16'hFFFF);
    end
    for (int w = 0; w < nw; w++) begin
      logic last;
      last = (w == nw - 1);
      drive((w == 0) && !lead_sof, 1'b1, last, last ? len[1:0] : 2'd0,
            {fb[4*w], fb[4*w+1], fb[4*w+2], fb[4*w+3]});
      if (gap && !last && (w % 2 == 0)) begin
        drive(1'b0, 1'b0, 1'b0, 2'd0, {rnd8(), rnd8(), rnd8(), rnd8()});
        chk("R8 gap keeps running value", crc, ref_crc(4*(w+1)));
      end
    end
    chk(tag, crc, exp);
    chk("R6 done pulse", {15'd0, done}, 16'd1);
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    chk("R6 done single cycle", {15'd0, done}, 16'd0);
    chk("R7 final value held", crc, exp);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset crc", crc, 16'hFFFF);
    chk("R1 reset done", {15'd0, done}, 16'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 after reset crc", crc, 16'hFFFF);

    fill_random();
    for (int k = 0; k < 9; k++) fb[k] = 8'h31 + k[7:0];
    run_frame(9, 1'b0, 1'b0);
    chk("R2 ascii digits vector", crc, 16'hAEE7);

    for (int len = 1; len <= 48; len++) begin
      for (int mode = 0; mode < 3; mode++) begin
        logic [15:0] held;
        fill_random();
        if (mode == 0)
          drive(1'b1, 1'b1, 1'b0, 2'd0, {rnd8(), rnd8(), rnd8(), rnd8()});
        run_frame(len, mode == 1, mode == 2);
        held = crc;
        drive(1'b0, 1'b1, 1'b1, 2'd0, {rnd8(), rnd8(), rnd8(), rnd8()});
        chk("R7 data without start ignored", crc, held);
        chk("R7 no pulse without start", {15'd0, done}, 16'd0);
        if (mode == 0 && len == 5)
          chk("R3 restart mid-frame", held, ref_crc(5));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule